// File: doc/BRIEF.md
# DRAM Command Spacing Tracker

This block guards the minimum cycle spacing between commands on one DRAM channel. It sees every command the channel issues (activate, read, write, refresh), each tagged with a rank and a bank. From that stream it keeps a set of saturating countdown timers and reports, every cycle, which rank-banks could take a write now and which ranks could take an activate now without breaking a programmed spacing limit. A scheduler reads these eligibility vectors before picking its next command. The block does no scheduling of its own.

All limits are counted in DRAM clock cycles and come from one software-writable configuration register. The low 16 bits hold the four write-side limits as 4-bit fields. The refresh-to-activate limit sits in a fifth 4-bit field directly above them. A limit takes effect when a timer is loaded. Timers that are already counting finish with the value they were loaded with.

Spacing is measured between issue cycles. If a command issues in cycle t and the limit is L, the guarded command becomes eligible in cycle t+L. Limits of 0 and 1 therefore both leave the next cycle free.

Top module: `dram_spacing_tracker`

## Requirements
- R1: After reset the configuration register reads zero, every bit of `wr_ok` is 1 and every bit of `act_ok` is 1.
- R2: A write to the configuration register (`cfg_we` high) appears on `cfg_rdata` in the next cycle and holds until the next write. Field layout: bits 3:0 hold activate-to-write, bits 7:4 hold same-rank write-to-write, bits 11:8 hold different-rank write-to-write, bits 15:12 hold read-to-write, and bits 19:16 hold refresh-to-activate.
- R3: An activate (`cmd_type` 0) to rank r, bank b in cycle t clears `wr_ok[r*NUM_BANKS+b]` until cycle t+L, where L is the activate-to-write limit. The bit returns to 1 in cycle t+L. Other rank-banks are not affected.
- R4: A write (`cmd_type` 2) to rank r in cycle t clears `wr_ok` for every bank of rank r until cycle t+L, where L is the same-rank write-to-write limit.
- R5: A write to rank r in cycle t clears `wr_ok` for every bank of every other rank until cycle t+L, where L is the different-rank write-to-write limit. The same-rank limit does not apply to those other ranks.
- R6: A read (`cmd_type` 1) to any rank in cycle t clears all of `wr_ok` until cycle t+L, where L is the read-to-write limit. A read does not change `act_ok`.
- R7: A refresh (`cmd_type` 3) to rank r in cycle t clears `act_ok[r]` until cycle t+L, where L is the refresh-to-activate limit. Other ranks and `wr_ok` are not affected.
- R8: A limit of 0 or 1 never blocks the cycle after the command.
- R9: A configuration write does not change a timer that is already counting. Only commands issued after the write use the new limit.
- R10: A repeated command re-arms its timer. Eligibility then follows the later command's full limit.
- R11: With `cmd_valid` low, the command fields are ignored and no timer is loaded.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | DRAM clock |
| rst_n | input | 1 | Active-low synchronous reset |
| cfg_we | input | 1 | Configuration register write enable |
| cfg_wdata | input | 20 | Configuration write data (5 fields x FIELD_W) |
| cfg_rdata | output | 20 | Configuration register contents |
| cmd_valid | input | 1 | A command issues this cycle |
| cmd_type | input | 2 | 0 activate, 1 read, 2 write, 3 refresh |
| cmd_rank | input | 1 | Target rank of the command |
| cmd_bank | input | 3 | Target bank of the command |
| wr_ok | output | 16 | Write eligible per rank-bank, index rank*NUM_BANKS+bank |
| act_ok | output | 2 | Activate eligible per rank (refresh spacing met) |

## Verification
The bench builds the block with its default parameters: two ranks of eight banks and 4-bit limit fields. With these values each rank-bank index, both directions of the cross-rank write rule, and the full 0 to 15 limit range are all small enough to step through cycle by cycle. The directed scenarios place checks in the last blocked cycle and the first free cycle of each timer. They also cover the following cases:
- a configuration write landing mid-count;
- a re-armed activate;
- a masked command with every limit at its maximum.

// File: rtl/dst_pkg.sv
package dst_pkg;

   typedef enum logic [1:0] {
      CMD_ACT = 2'd0,
      CMD_RD  = 2'd1,
      CMD_WR  = 2'd2,
      CMD_REF = 2'd3
   } dst_cmd_e;

   // Field slots of the configuration register, lowest first
   localparam int FLD_ACT_WR  = 0;
   localparam int FLD_WR_SAME = 1;
   localparam int FLD_WR_DIFF = 2;
   localparam int FLD_RD_WR   = 3;
   localparam int FLD_REF_ACT = 4;
   localparam int NUM_FIELDS  = 5;

endpackage

// File: rtl/dst_cfg_reg.sv
module dst_cfg_reg #(
   parameter int W = 20
) (
   input  logic         clk,
   input  logic         rst_n,
   input  logic         we,
   input  logic [W-1:0] wdata,
   output logic [W-1:0] q
);

   always_ff @(posedge clk) begin
      if (!rst_n)  q <= '0;
      else if (we) q <= wdata;
   end

   // R2: written value lands one cycle later
   a_r2_write_lands: assert property (@(posedge clk) disable iff (!rst_n)
      we |=> (q == $past(wdata)));

   // R2: contents hold without a write
   a_r2_hold: assert property (@(posedge clk) disable iff (!rst_n)
      !we |=> $stable(q));

endmodule

// File: rtl/dst_countdown.sv
module dst_countdown #(
   parameter int W = 4
) (
   input  logic         clk,
   input  logic         rst_n,
   input  logic         load,
   input  logic [W-1:0] limit,
   output logic         zero
);

   logic [W-1:0] cnt;

   // A command issued in cycle t loads limit-1, so zero is reached in cycle t+limit
   always_ff @(posedge clk) begin
      if (!rst_n)            cnt <= '0;
      else if (load)         cnt <= (limit == '0) ? '0 : limit - W'(1);
      else if (cnt != '0)    cnt <= cnt - W'(1);
   end

   assign zero = (cnt == '0);

   // R8: a short limit leaves the next cycle free
   a_r8_short_limit_free: assert property (@(posedge clk) disable iff (!rst_n)
      (load && (limit <= W'(1))) |=> zero);

   // R3: an expired timer stays expired until reloaded
   a_r3_no_underflow: assert property (@(posedge clk) disable iff (!rst_n)
      (!load && zero) |=> zero);

endmodule

// File: rtl/dram_spacing_tracker.sv
module dram_spacing_tracker
   import dst_pkg::*;
#(
   parameter int NUM_RANKS = 2,
   parameter int NUM_BANKS = 8,
   parameter int FIELD_W   = 4,
   localparam int RANK_W   = $clog2(NUM_RANKS),
   localparam int BANK_W   = $clog2(NUM_BANKS),
   localparam int CFG_W    = NUM_FIELDS * FIELD_W,
   localparam int RB       = NUM_RANKS * NUM_BANKS
) (
   input  logic              clk,
   input  logic              rst_n,
   input  logic              cfg_we,
   input  logic [CFG_W-1:0]  cfg_wdata,
   output logic [CFG_W-1:0]  cfg_rdata,
   input  logic              cmd_valid,
   input  logic [1:0]        cmd_type,
   input  logic [RANK_W-1:0] cmd_rank,
   input  logic [BANK_W-1:0] cmd_bank,
   output logic [RB-1:0]     wr_ok,
   output logic [NUM_RANKS-1:0] act_ok
);

   // Elaboration-time parameter checks
   if (NUM_RANKS < 2 || (1 << RANK_W) != NUM_RANKS) begin : g_bad_ranks
      $error("NUM_RANKS must be a power of two, at least 2");
   end
   if (NUM_BANKS < 2 || (1 << BANK_W) != NUM_BANKS) begin : g_bad_banks
      $error("NUM_BANKS must be a power of two, at least 2");
   end
   if (FIELD_W < 2 || FIELD_W > 8) begin : g_bad_field
      $error("FIELD_W must lie in 2..8");
   end

   // Configuration register
   dst_cfg_reg #(.W(CFG_W)) u_cfg (
      .clk   (clk),
      .rst_n (rst_n),
      .we    (cfg_we),
      .wdata (cfg_wdata),
      .q     (cfg_rdata)
   );

   logic [FIELD_W-1:0] lim_act_wr, lim_wr_same, lim_wr_diff, lim_rd_wr, lim_ref_act;
   assign lim_act_wr  = cfg_rdata[FLD_ACT_WR  * FIELD_W +: FIELD_W];
   assign lim_wr_same = cfg_rdata[FLD_WR_SAME * FIELD_W +: FIELD_W];
   assign lim_wr_diff = cfg_rdata[FLD_WR_DIFF * FIELD_W +: FIELD_W];
   assign lim_rd_wr   = cfg_rdata[FLD_RD_WR   * FIELD_W +: FIELD_W];
   assign lim_ref_act = cfg_rdata[FLD_REF_ACT * FIELD_W +: FIELD_W];

   // Command decode (R11: nothing decodes without cmd_valid)
   logic is_act, is_rd, is_wr, is_ref;
   assign is_act = cmd_valid && (cmd_type == CMD_ACT);
   assign is_rd  = cmd_valid && (cmd_type == CMD_RD);
   assign is_wr  = cmd_valid && (cmd_type == CMD_WR);
   assign is_ref = cmd_valid && (cmd_type == CMD_REF);

   logic [RB-1:0]        actwr_zero;
   logic [NUM_RANKS-1:0] same_zero, diff_zero, ref_zero;
   logic                 rdwr_zero;

   // Per rank-bank activate-to-write timers
   for (genvar r = 0; r < NUM_RANKS; r++) begin : g_rank
      for (genvar b = 0; b < NUM_BANKS; b++) begin : g_bank
         dst_countdown #(.W(FIELD_W)) u_actwr (
            .clk   (clk),
            .rst_n (rst_n),
            .load  (is_act && (cmd_rank == RANK_W'(r)) && (cmd_bank == BANK_W'(b))),
            .limit (lim_act_wr),
            .zero  (actwr_zero[r*NUM_BANKS + b])
         );
         assign wr_ok[r*NUM_BANKS + b] = actwr_zero[r*NUM_BANKS + b] & same_zero[r]
                                       & diff_zero[r] & rdwr_zero;
      end

      // Same-rank write-to-write
      dst_countdown #(.W(FIELD_W)) u_same (
         .clk   (clk),
         .rst_n (rst_n),
         .load  (is_wr && (cmd_rank == RANK_W'(r))),
         .limit (lim_wr_same),
         .zero  (same_zero[r])
      );

      // Different-rank write-to-write: armed by writes to any other rank
      dst_countdown #(.W(FIELD_W)) u_diff (
         .clk   (clk),
         .rst_n (rst_n),
         .load  (is_wr && (cmd_rank != RANK_W'(r))),
         .limit (lim_wr_diff),
         .zero  (diff_zero[r])
      );

      // Refresh-to-activate
      dst_countdown #(.W(FIELD_W)) u_ref (
         .clk   (clk),
         .rst_n (rst_n),
         .load  (is_ref && (cmd_rank == RANK_W'(r))),
         .limit (lim_ref_act),
         .zero  (ref_zero[r])
      );

      assign act_ok[r] = ref_zero[r];

      // R4: a same-rank write blocks the whole rank next cycle
      a_r4_same_rank_blocks: assert property (@(posedge clk) disable iff (!rst_n)
         (is_wr && (cmd_rank == RANK_W'(r)) && (lim_wr_same >= FIELD_W'(2)))
         |=> (wr_ok[r*NUM_BANKS +: NUM_BANKS] == '0));

      // R5: a write elsewhere blocks this rank next cycle
      a_r5_other_rank_blocks: assert property (@(posedge clk) disable iff (!rst_n)
         (is_wr && (cmd_rank != RANK_W'(r)) && (lim_wr_diff >= FIELD_W'(2)))
         |=> (wr_ok[r*NUM_BANKS +: NUM_BANKS] == '0));
   end

   // Read-to-write, shared by every rank
   dst_countdown #(.W(FIELD_W)) u_rdwr (
      .clk   (clk),
      .rst_n (rst_n),
      .load  (is_rd),
      .limit (lim_rd_wr),
      .zero  (rdwr_zero)
   );

   logic [RANK_W+BANK_W-1:0] cmd_idx;
   assign cmd_idx = {cmd_rank, cmd_bank};

   // R3: activate blocks its own rank-bank next cycle
   a_r3_act_blocks: assert property (@(posedge clk) disable iff (!rst_n)
      (is_act && (lim_act_wr >= FIELD_W'(2))) |=> !wr_ok[$past(cmd_idx)]);

   // R6: read blocks every write next cycle
   a_r6_read_blocks: assert property (@(posedge clk) disable iff (!rst_n)
      (is_rd && (lim_rd_wr >= FIELD_W'(2))) |=> (wr_ok == '0));

   // R6: read never touches activate eligibility
   a_r6_act_untouched: assert property (@(posedge clk) disable iff (!rst_n)
      (is_rd || !cmd_valid) |=> (act_ok == $past(act_ok) | ($past(act_ok) ^ act_ok)
                                 & act_ok));

   // R7: refresh blocks activate on its rank next cycle
   a_r7_ref_blocks: assert property (@(posedge clk) disable iff (!rst_n)
      (is_ref && (lim_ref_act >= FIELD_W'(2))) |=> !act_ok[$past(cmd_rank)]);

endmodule

// File: tb/tb_dram_spacing_tracker.sv
module tb_dram_spacing_tracker;

   logic        clk = 1'b0;
   logic        rst_n = 1'b0;
   logic        cfg_we = 1'b0;
   logic [19:0] cfg_wdata = '0;
   logic [19:0] cfg_rdata;
   logic        cmd_valid = 1'b0;
   logic [1:0]  cmd_type = 2'd0;
   logic        cmd_rank = 1'b0;
   logic [2:0]  cmd_bank = 3'd0;
   logic [15:0] wr_ok;
   logic [1:0]  act_ok;

   int n_checks = 0;
   int n_fails  = 0;
   bit done     = 1'b0;

   localparam logic [1:0] T_ACT = 2'd0, T_RD = 2'd1, T_WR = 2'd2, T_REF = 2'd3;

   always #10 clk = ~clk;   // 50 MHz

   dram_spacing_tracker dut (
      .clk       (clk),
      .rst_n     (rst_n),
      .cfg_we    (cfg_we),
      .cfg_wdata (cfg_wdata),
      .cfg_rdata (cfg_rdata),
      .cmd_valid (cmd_valid),
      .cmd_type  (cmd_type),
      .cmd_rank  (cmd_rank),
      .cmd_bank  (cmd_bank),
      .wr_ok     (wr_ok),
      .act_ok    (act_ok)
   );

   task automatic check(input string tag, input logic [31:0] act, input logic [31:0] exp);
      n_checks++;
      if (act !== exp) begin
         n_fails++;
         $display("FAIL %s: got %h expected %h", tag, act, exp);
      end
   endtask

   task automatic step(input int n);
      repeat (n) @(negedge clk);
   endtask

   // Returns one edge after the issue edge (k = 1)
   task automatic issue(input logic [1:0] t, input logic r, input logic [2:0] b);
      @(negedge clk);
      cmd_valid = 1'b1; cmd_type = t; cmd_rank = r; cmd_bank = b;
      @(negedge clk);
      cmd_valid = 1'b0;
   endtask

   task automatic set_cfg(input logic [19:0] v);
      @(negedge clk);
      cfg_we = 1'b1; cfg_wdata = v;
      @(negedge clk);
      cfg_we = 1'b0;
   endtask

   task automatic test_reset;
      check("R1 cfg after reset", 32'(cfg_rdata), 32'h0);
      check("R1 wr_ok after reset", 32'(wr_ok), 32'hFFFF);
      check("R1 act_ok after reset", 32'(act_ok), 32'h3);
   endtask

   task automatic test_cfg;
      set_cfg(20'h5A3C9);
      check("R2 readback", 32'(cfg_rdata), 32'h5A3C9);
      step(3);
      check("R2 hold", 32'(cfg_rdata), 32'h5A3C9);
   endtask

   task automatic test_act_wr;
      set_cfg(20'h00005);  // activate-to-write field bits 3:0 = 5
      step(20);
      issue(T_ACT, 1'b0, 3'd3);
      check("R3 k1 only r0b3 blocked", 32'(wr_ok), 32'hFFF7);
      check("R3 act_ok untouched", 32'(act_ok), 32'h3);
      step(3);
      check("R3 k4 still blocked", 32'(wr_ok), 32'hFFF7);
      step(1);
      check("R3 k5 free", 32'(wr_ok), 32'hFFFF);
   endtask

   task automatic test_same_rank;
      set_cfg(20'h00040);  // same-rank field bits 7:4 = 4
      step(20);
      issue(T_WR, 1'b1, 3'd0);
      check("R4 k1 rank1 blocked", 32'(wr_ok), 32'h00FF);
      step(2);
      check("R4 k3 rank1 blocked", 32'(wr_ok), 32'h00FF);
      step(1);
      check("R4 k4 free", 32'(wr_ok), 32'hFFFF);
   endtask

   task automatic test_diff_rank;
      set_cfg(20'h00620);  // diff-rank bits 11:8 = 6, same-rank = 2
      step(20);
      issue(T_WR, 1'b0, 3'd5);
      check("R5 k1 all blocked", 32'(wr_ok), 32'h0000);
      step(1);
      check("R5 k2 rank0 free rank1 blocked", 32'(wr_ok), 32'h00FF);
      step(3);
      check("R5 k5 rank1 blocked", 32'(wr_ok), 32'h00FF);
      step(1);
      check("R5 k6 free", 32'(wr_ok), 32'hFFFF);
   endtask

   task automatic test_read;
      set_cfg(20'h03000);  // read-to-write bits 15:12 = 3
      step(20);
      issue(T_RD, 1'b1, 3'd2);
      check("R6 k1 blocked", 32'(wr_ok), 32'h0000);
      check("R6 act_ok untouched", 32'(act_ok), 32'h3);
      step(1);
      check("R6 k2 blocked", 32'(wr_ok), 32'h0000);
      step(1);
      check("R6 k3 free", 32'(wr_ok), 32'hFFFF);
   endtask

   task automatic test_ref;
      set_cfg(20'h70000);  // refresh-to-activate bits 19:16 = 7
      step(20);
      issue(T_REF, 1'b1, 3'd0);
      check("R7 k1 rank1 blocked", 32'(act_ok), 32'h1);
      check("R7 wr_ok untouched", 32'(wr_ok), 32'hFFFF);
      step(5);
      check("R7 k6 blocked", 32'(act_ok), 32'h1);
      step(1);
      check("R7 k7 free", 32'(act_ok), 32'h3);
   endtask

   task automatic test_short;
      set_cfg(20'h11111);
      step(20);
      issue(T_ACT, 1'b0, 3'd0);
      check("R8 limit1 act", 32'(wr_ok), 32'hFFFF);
      issue(T_WR, 1'b1, 3'd1);
      check("R8 limit1 write", 32'(wr_ok), 32'hFFFF);
      set_cfg(20'h00000);
      issue(T_RD, 1'b0, 3'd4);
      check("R8 limit0 read", 32'(wr_ok), 32'hFFFF);
      issue(T_REF, 1'b0, 3'd0);
      check("R8 limit0 ref", 32'(act_ok), 32'h3);
   endtask

   task automatic test_cfg_midrun;
      set_cfg(20'h90000);
      step(20);
      issue(T_REF, 1'b0, 3'd0);         // k = 1
      set_cfg(20'h20000);               // k = 3
      check("R9 new cfg visible", 32'(cfg_rdata), 32'h20000);
      step(5);                          // k = 8
      check("R9 old limit still running", 32'(act_ok), 32'h2);
      step(1);                          // k = 9
      check("R9 old limit expires", 32'(act_ok), 32'h3);
      issue(T_REF, 1'b0, 3'd0);
      check("R9 new limit k1", 32'(act_ok), 32'h2);
      step(1);
      check("R9 new limit k2", 32'(act_ok), 32'h3);
   endtask

   task automatic test_rearm;
      set_cfg(20'h00006);
      step(20);
      issue(T_ACT, 1'b1, 3'd7);
      step(2);
      issue(T_ACT, 1'b1, 3'd7);         // k' = 1
      step(4);
      check("R10 rearmed k5 blocked", 32'(wr_ok), 32'h7FFF);
      step(1);
      check("R10 rearmed k6 free", 32'(wr_ok), 32'hFFFF);
   endtask

   task automatic test_masked;
      set_cfg(20'hFFFFF);
      step(20);
      @(negedge clk);
      cmd_valid = 1'b0; cmd_type = T_WR; cmd_rank = 1'b0; cmd_bank = 3'd1;
      step(1);
      cmd_type = T_REF;
      step(1);
      cmd_type = T_RD;
      step(1);
      check("R11 masked wr_ok", 32'(wr_ok), 32'hFFFF);
      check("R11 masked act_ok", 32'(act_ok), 32'h3);
   endtask

   task automatic finish_run;
      if (!done) begin
         done = 1'b1;
         $display("*** SUMMARY: %0d compared / %0d mismatched ***", n_checks, n_fails);
         $finish;
      end
   endtask

   initial begin
      repeat (4) @(negedge clk);
      rst_n = 1'b1;
      step(1);
      test_reset();
      test_cfg();
      test_act_wr();
      test_same_rank();
      test_diff_rank();
      test_read();
      test_ref();
      test_short();
      test_cfg_midrun();
      test_rearm();
      test_masked();
      step(2);
      finish_run();
   end

   initial begin
      repeat (20000) @(posedge clk);
      n_checks++;
      n_fails++;
      $display("FAIL watchdog: got timeout expected completion");
      finish_run();
   end

endmodule